// File: doc/BRIEF.md
# Dual-Channel Indirect Register Access Unit

This unit is the host-facing register front end of a two-channel serial controller. A byte-wide bus with one-cycle read and write strobes reaches it through a small address. One address bit picks between a control port and a data port. The next higher bit picks the channel. Each channel has sixteen write registers and sixteen read registers. A control access reaches them in two steps: a first control write loads a per-channel register pointer, and the next control access uses that pointer and then sets it back to zero.

The unit holds the reset contents of every register and decodes the channel-reset commands. It also keeps the status bits that data-port accesses change: receive-available, transmit-empty and all-sent. It latches the received byte and decides whether the receive side may deliver another one. It gives the serial machinery a transmit strobe and byte, a receive-ready flag and the flattened write-register contents. The shifters, baud generation and interrupt vectoring are not part of this unit.

Top module: `sercom_regif`

## Requirements
- R1: Address bit `SHIFT` selects the control port (0) or the data port (1). Address bit `SHIFT+1` selects the channel: 1 is channel A and 0 is channel B. At most one access takes effect in a cycle. When `rd_en` and `wr_en` are both high, the read is performed and the write is ignored.
- R2: A control write made while the channel pointer is zero loads the pointer from data bits 2:0. When bits 5:3 equal 001, the pointer also gets bit 3 set, which reaches registers 8 to 15.
- R3: A control write made while the pointer is nonzero stores the byte in the pointed write register and clears the pointer. A control read returns the pointed read register and clears the pointer. Data-port accesses leave the pointer unchanged.
- R4: A write to register 9 is never stored. Its bits 7:6 are a reset command: 01 resets channel B, 10 resets channel A, 11 resets both, and 00 has no effect.
- R5: A channel reset, whether from `rst_n` low or from a reset command, does the following. It clears the pointer, the received byte and all registers. It then sets write register 4 to 0x04, register 9 to 0xC0, register 11 to 0x08, register 14 to 0x30 and register 15 to 0xF8, and read register 1 to 0x07. Read registers other than 0, 1, 12 and 13 always read 0x00.
- R6: After a channel reset, read register 0 is 0x44. It is 0x7C if `chan_off` is high in the cycle of the reset.
- R7: A write to register 12 or 13 also appears in read register 12 or 13.
- R8: A data write raises `tx_pulse` for that channel for one cycle, starting the next cycle, with the byte on `tx_byte`. It also sets bit 2 of read register 0 and bit 0 of read register 1.
- R9: `rx_ready` is high only when bit 0 of write register 3 is set and bit 0 of read register 0 (receive-available) is clear. An `rx_load` is taken only while `rx_ready` is high; it latches the byte and sets receive-available. A data read returns the latched byte and clears receive-available. A load in the same cycle as that read wins.
- R10: `rdata` changes one cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of both channels |
| addr | input | SHIFT+2 | Port select at bit SHIFT, channel select at bit SHIFT+1 |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| chan_off | input | 1 | Selects the parked status value loaded into read register 0 at reset |
| rx_load | input | 2 | Received byte offered, per channel (bit 1 = A) |
| rx_data | input | 16 | Received bytes, channel A in bits 15:8 |
| rx_ready | output | 2 | Receive side may deliver, per channel |
| tx_pulse | output | 2 | Transmit strobe, per channel |
| tx_byte | output | 8 | Byte for the transmit strobe |
| cfg_regs | output | 256 | Write registers; channel c, register r at bits c*128+r*8 +: 8 |

## Verification
The bench goes after the two-step pointer. Errors it targets include a pointer that stays set after an access, a point-high command that fails to add 8, and a data access that clears the pointer by mistake; any of these shows up as a read of the wrong register. It drives reset commands across channels, so a decoder with the channel bits swapped resets the wrong channel. A design that stores register 9 also shows up in the register contents. It offers receive bytes while receive-available is set and while receive is disabled, so an overwritten byte or a lost read comes back as the wrong data. It also raises both strobes in one cycle and changes `chan_off` across resets; a wrong reset value or a write that should have been dropped is then visible.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

  localparam int BYTE_W   = 8;
  localparam int NREG     = 16;
  localparam int PTR_W    = $clog2(NREG);
  localparam int NCH      = 2;
  localparam int CH_CFG_W = NREG * BYTE_W;

  localparam int REG_RXCTL  = 3;
  localparam int REG_RSTCMD = 9;
  localparam int REG_BAUDLO = 12;
  localparam int REG_BAUDHI = 13;

  // reset contents of the write registers
  function automatic logic [BYTE_W-1:0] wreg_init(input int idx);
    case (idx)
      4:       return 8'h04;
      9:       return 8'hC0;
      11:      return 8'h08;
      14:      return 8'h30;
      15:      return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

  // reset contents of status register 0
  function automatic logic [BYTE_W-1:0] stat0_init(input logic parked);
    return parked ? 8'h7C : 8'h44;
  endfunction

  // pointer loaded by a control write while the pointer is zero
  function automatic logic [PTR_W-1:0] ptr_load(input logic [BYTE_W-1:0] cmd);
    return {(cmd[5:3] == 3'b001), cmd[2:0]};
  endfunction

endpackage

// File: rtl/sercom_decode.sv
module sercom_decode #(
  parameter int SHIFT  = 0,
  parameter int ADDR_W = SHIFT + 2
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr_en,
  input  logic                     rd_en,
  output logic [sercom_pkg::NCH-1:0] ctl_wr,
  output logic [sercom_pkg::NCH-1:0] ctl_rd,
  output logic [sercom_pkg::NCH-1:0] dat_wr,
  output logic [sercom_pkg::NCH-1:0] dat_rd
);
  import sercom_pkg::*;

  logic is_data;
  logic ch_sel;
  logic do_rd;
  logic do_wr;

  assign is_data = addr[SHIFT];
  assign ch_sel  = addr[SHIFT+1];
  assign do_rd   = rd_en;
  assign do_wr   = wr_en & ~rd_en;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit       = (ch_sel == c[0]);
    assign ctl_wr[c] = hit & do_wr & ~is_data;
    assign ctl_rd[c] = hit & do_rd & ~is_data;
    assign dat_wr[c] = hit & do_wr &  is_data;
    assign dat_rd[c] = hit & do_rd &  is_data;
  end

endmodule

// File: rtl/sercom_chan.sv
module sercom_chan
  import sercom_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 parked,
  input  logic                 cmd_rst,
  input  logic                 ctl_wr,
  input  logic                 ctl_rd,
  input  logic                 dat_wr,
  input  logic                 dat_rd,
  input  logic [BYTE_W-1:0]    wdata,
  input  logic                 rx_load,
  input  logic [BYTE_W-1:0]    rx_byte,
  output logic [BYTE_W-1:0]    rd_byte,
  output logic                 rx_ready,
  output logic                 tx_pulse,
  output logic [NCH-1:0]       rst_req,
  output logic [CH_CFG_W-1:0]  cfg,
  output logic [PTR_W-1:0]     ptr_o,
  output logic                 rxav_o
);

  logic [PTR_W-1:0]  ptr_q;
  logic [BYTE_W-1:0] stat0_q;
  logic [BYTE_W-1:0] stat1_q;
  logic [BYTE_W-1:0] baud_lo_q;
  logic [BYTE_W-1:0] baud_hi_q;
  logic [BYTE_W-1:0] rx_hold_q;
  logic [BYTE_W-1:0] wreg [NREG];

  logic init;
  logic ptr_zero;
  logic reg_wr;
  logic rx_take;

  assign init     = ~rst_n | cmd_rst;
  assign ptr_zero = (ptr_q == '0);
  assign reg_wr   = ctl_wr & ~ptr_zero;
  assign rx_ready = wreg[REG_RXCTL][0] & ~stat0_q[0];
  assign rx_take  = rx_load & rx_ready;

  assign rst_req  = (reg_wr && ptr_q == PTR_W'(REG_RSTCMD)) ? wdata[7:6] : '0;

  // write registers: 0 is the command port, 9 the reset command; neither stored
  for (genvar g = 0; g < NREG; g++) begin : g_wreg
    if (g == 0 || g == REG_RSTCMD) begin : g_fixed
      assign wreg[g] = wreg_init(g);
    end else begin : g_flop
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk) begin
        if (init)
          q <= wreg_init(g);
        else if (reg_wr && ptr_q == PTR_W'(g))
          q <= wdata;
      end
      assign wreg[g] = q;
    end
    assign cfg[g*BYTE_W +: BYTE_W] = wreg[g];
  end

  always_ff @(posedge clk) begin
    if (init)
      ptr_q <= '0;
    else if (ctl_wr && ptr_zero)
      ptr_load_step: ptr_q <= ptr_load(wdata);
    else if (ctl_wr || ctl_rd)
      ptr_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (init) begin
      stat0_q   <= stat0_init(parked);
      stat1_q   <= 8'h07;
      baud_lo_q <= '0;
      baud_hi_q <= '0;
      rx_hold_q <= '0;
      tx_pulse  <= 1'b0;
    end else begin
      tx_pulse <= dat_wr;
      if (dat_wr) begin
        stat0_q[2] <= 1'b1;
        stat1_q[0] <= 1'b1;
      end
      if (rx_take) begin
        stat0_q[0] <= 1'b1;
        rx_hold_q  <= rx_byte;
      end else if (dat_rd) begin
        stat0_q[0] <= 1'b0;
      end
      if (reg_wr && ptr_q == PTR_W'(REG_BAUDLO)) baud_lo_q <= wdata;
      if (reg_wr && ptr_q == PTR_W'(REG_BAUDHI)) baud_hi_q <= wdata;
    end
  end

  function automatic logic [BYTE_W-1:0] rreg_sel(input logic [PTR_W-1:0] p);
    case (p)
      PTR_W'(0):          return stat0_q;
      PTR_W'(1):          return stat1_q;
      PTR_W'(REG_BAUDLO): return baud_lo_q;
      PTR_W'(REG_BAUDHI): return baud_hi_q;
      default:            return '0;
    endcase
  endfunction

  assign rd_byte = ctl_rd ? rreg_sel(ptr_q) : rx_hold_q;
  assign ptr_o   = ptr_q;
  assign rxav_o  = stat0_q[0];

endmodule

// File: rtl/sercom_regif.sv
module sercom_regif #(
  parameter int SHIFT = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SHIFT+1:0]     addr,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  input  logic                 chan_off,
  input  logic [1:0]           rx_load,
  input  logic [15:0]          rx_data,
  output logic [1:0]           rx_ready,
  output logic [1:0]           tx_pulse,
  output logic [7:0]           tx_byte,
  output logic [255:0]         cfg_regs
);
  import sercom_pkg::*;

  localparam int ADDR_W = SHIFT + 2;

  // named events for the checker
  logic [NCH-1:0]       ctl_wr_v, ctl_rd_v, dat_wr_v, dat_rd_v;
  logic [NCH*PTR_W-1:0] ptr_flat;
  logic [NCH-1:0]       rxav_v;
  logic [NCH-1:0]       clr_req;
  logic [NCH-1:0]       req_from [NCH];
  logic [BYTE_W-1:0]    rd_byte_v [NCH];
  logic                 ch_sel;

  assign ch_sel = addr[SHIFT+1];

  sercom_decode #(.SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_dec (
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .ctl_wr (ctl_wr_v),
    .ctl_rd (ctl_rd_v),
    .dat_wr (dat_wr_v),
    .dat_rd (dat_rd_v)
  );

  assign clr_req = req_from[0] | req_from[1];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    sercom_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .parked   (chan_off),
      .cmd_rst  (clr_req[c]),
      .ctl_wr   (ctl_wr_v[c]),
      .ctl_rd   (ctl_rd_v[c]),
      .dat_wr   (dat_wr_v[c]),
      .dat_rd   (dat_rd_v[c]),
      .wdata    (wdata),
      .rx_load  (rx_load[c]),
      .rx_byte  (rx_data[c*BYTE_W +: BYTE_W]),
      .rd_byte  (rd_byte_v[c]),
      .rx_ready (rx_ready[c]),
      .tx_pulse (tx_pulse[c]),
      .rst_req  (req_from[c]),
      .cfg      (cfg_regs[c*CH_CFG_W +: CH_CFG_W]),
      .ptr_o    (ptr_flat[c*PTR_W +: PTR_W]),
      .rxav_o   (rxav_v[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata   <= '0;
      tx_byte <= '0;
    end else begin
      if (rd_en)
        rdata <= rd_byte_v[ch_sel];
      if (|dat_wr_v)
        tx_byte <= wdata;
    end
  end

endmodule

// File: rtl/sercom_regif_chk.sv
module sercom_regif_chk #(
  parameter int SHIFT = 0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rd_en,
  input logic [7:0]   wdata,
  input logic [7:0]   rdata,
  input logic [1:0]   rx_load,
  input logic [1:0]   rx_ready,
  input logic [1:0]   tx_pulse,
  input logic [1:0]   ctl_wr_v,
  input logic [1:0]   ctl_rd_v,
  input logic [1:0]   dat_wr_v,
  input logic [1:0]   dat_rd_v,
  input logic [7:0]   ptr_flat,
  input logic [1:0]   rxav_v,
  input logic [1:0]   clr_req
);

  a_r1_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_wr_v, ctl_rd_v, dat_wr_v, dat_rd_v}));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  for (genvar i = 0; i < 2; i++) begin : g_ch
    logic [3:0] ptr;
    assign ptr = ptr_flat[i*4 +: 4];

    a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr_v[i] && ptr == 4'd0 |=>
        ptr == {($past(wdata[5:3]) == 3'b001), $past(wdata[2:0])});

    a_r3_ptr_clear_read: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rd_v[i] |=> ptr == 4'd0);

    a_r3_ptr_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr_v[i] && ptr != 4'd0 |=> ptr == 4'd0);

    a_r5_cmd_reset: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req[i] |=> ptr == 4'd0 && !rxav_v[i] && !rx_ready[i]);

    a_r8_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr_v[i] |=> tx_pulse[i]);

    a_r9_refused_load: assert property (@(posedge clk) disable iff (!rst_n)
      rx_load[i] && !rx_ready[i] && !clr_req[i] && !dat_rd_v[i] |=>
        rxav_v[i] == $past(rxav_v[i]));
  end

endmodule

bind sercom_regif sercom_regif_chk #(.SHIFT(SHIFT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .wdata    (wdata),
  .rdata    (rdata),
  .rx_load  (rx_load),
  .rx_ready (rx_ready),
  .tx_pulse (tx_pulse),
  .ctl_wr_v (ctl_wr_v),
  .ctl_rd_v (ctl_rd_v),
  .dat_wr_v (dat_wr_v),
  .dat_rd_v (dat_rd_v),
  .ptr_flat (ptr_flat),
  .rxav_v   (rxav_v),
  .clr_req  (clr_req)
);

// File: tb/sim_sercom_regif.sv
`timescale 1ns/1ps
module sim_sercom_regif;
  localparam int SH = 1;
  localparam int AW = SH + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          chan_off = 1'b0;
  logic [1:0]    rx_load = '0;
  logic [15:0]   rx_data = '0;
  logic [1:0]    rx_ready, tx_pulse;
  logic [7:0]    tx_byte;
  logic [255:0]  cfg_regs;

  always #4 clk = ~clk;

  sercom_regif #(.SHIFT(SH)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .chan_off(chan_off), .rx_load(rx_load),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_pulse(tx_pulse),
    .tx_byte(tx_byte), .cfg_regs(cfg_regs)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference state, channel 1 = A, 0 = B
  int         m_ptr [2];
  logic [7:0] m_w [2][16];
  logic [7:0] m_s0 [2], m_s1 [2], m_b12 [2], m_b13 [2], m_rx [2];
  logic [7:0] m_rdata = 0, m_txb = 0;
  logic [1:0] m_txp = 0;

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic m_reset(int c);
    m_ptr[c] = 0;
    for (int r = 0; r < 16; r++) m_w[c][r] = 8'h00;
    m_w[c][4] = 8'h04; m_w[c][9] = 8'hC0; m_w[c][11] = 8'h08;
    m_w[c][14] = 8'h30; m_w[c][15] = 8'hF8;
    m_s0[c] = chan_off ? 8'h7C : 8'h44;
    m_s1[c] = 8'h07; m_b12[c] = 0; m_b13[c] = 0; m_rx[c] = 0;
  endtask

  function automatic logic [7:0] m_read(int c, int p);
    if (p == 0) return m_s0[c];
    if (p == 1) return m_s1[c];
    if (p == 12) return m_b12[c];
    if (p == 13) return m_b13[c];
    return 8'h00;
  endfunction

  function automatic bit m_ready(int c);
    return m_w[c][3][0] && !m_s0[c][0];
  endfunction

  task automatic m_step();
    int ch, sel, p;
    bit rdy [2];
    logic [1:0] kill;
    if (!rst_n) begin
      m_reset(0); m_reset(1); m_rdata = 0; m_txb = 0; m_txp = 0;
      return;
    end
    kill = 0; m_txp = 0;
    ch = addr[SH+1]; sel = addr[SH];
    for (int c = 0; c < 2; c++) rdy[c] = m_ready(c);
    if (rd_en) begin
      if (sel == 0) begin m_rdata = m_read(ch, m_ptr[ch]); m_ptr[ch] = 0; end
      else begin m_rdata = m_rx[ch]; m_s0[ch][0] = 1'b0; end
    end else if (wr_en) begin
      if (sel == 1) begin
        m_txp[ch] = 1'b1; m_txb = wdata; m_s0[ch][2] = 1'b1; m_s1[ch][0] = 1'b1;
      end else if (m_ptr[ch] == 0) begin
        m_ptr[ch] = wdata[2:0] + ((wdata[5:3] == 3'd1) ? 8 : 0);
      end else begin
        p = m_ptr[ch]; m_ptr[ch] = 0;
        if (p == 9) kill = wdata[7:6];
        else begin
          m_w[ch][p] = wdata;
          if (p == 12) m_b12[ch] = wdata;
          if (p == 13) m_b13[ch] = wdata;
        end
      end
    end
    for (int c = 0; c < 2; c++)
      if (rx_load[c] && rdy[c]) begin m_s0[c][0] = 1'b1; m_rx[c] = rx_data[c*8 +: 8]; end
    for (int c = 0; c < 2; c++) if (kill[c]) m_reset(c);
  endtask

  task automatic compare_all();
    logic [255:0] ecfg;
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 16; r++) ecfg[c*128 + r*8 +: 8] = m_w[c][r];
    chk("R10 rdata", rdata, m_rdata);
    chk("R9 rx_ready", rx_ready, {m_ready(1), m_ready(0)});
    chk("R8 tx_pulse", tx_pulse, m_txp);
    chk("R8 tx_byte", tx_byte, m_txb);
    chk("R5 cfg_regs", cfg_regs, ecfg);
  endtask

  task automatic step();
    @(posedge clk); #1;
    m_step();
    compare_all();
    wr_en = 0; rd_en = 0; rx_load = 0;
  endtask

  function automatic logic [AW-1:0] ad(int ch, int sel);
    return AW'((ch << (SH + 1)) | (sel << SH));
  endfunction

  task automatic ctl_wr(int ch, logic [7:0] v);
    addr = ad(ch, 0); wdata = v; wr_en = 1; step();
  endtask
  task automatic ctl_rd(int ch);
    addr = ad(ch, 0); rd_en = 1; step();
  endtask
  task automatic reg_wr(int ch, int r, logic [7:0] v);
    ctl_wr(ch, (r >= 8) ? 8'(8'h08 | (r - 8)) : 8'(r));
    ctl_wr(ch, v);
  endtask
  task automatic reg_rd(int ch, int r);
    if (r != 0) ctl_wr(ch, (r >= 8) ? 8'(8'h08 | (r - 8)) : 8'(r));
    ctl_rd(ch);
  endtask
  task automatic dat_wr(int ch, logic [7:0] v);
    addr = ad(ch, 1); wdata = v; wr_en = 1; step();
  endtask
  task automatic dat_rd(int ch);
    addr = ad(ch, 1); rd_en = 1; step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    // R5: reset contents
    chk("R5 rdata reset", rdata, 8'h00);
    chk("R5 reg4 A", cfg_regs[128 + 4*8 +: 8], 8'h04);
    chk("R5 reg9 B", cfg_regs[9*8 +: 8], 8'hC0);
    chk("R5 reg15 A", cfg_regs[128 + 15*8 +: 8], 8'hF8);
    chk("R9 rx_ready reset", rx_ready, 2'b00);
    // R6: status after reset
    ctl_rd(1); chk("R6 A status", rdata, 8'h44);
    ctl_rd(0); chk("R6 B status", rdata, 8'h44);
    reg_rd(1, 1); chk("R5 A rreg1", rdata, 8'h07);
    reg_rd(1, 5); chk("R5 A rreg5 zero", rdata, 8'h00);
    // R2 R7: point high reaches baud registers, mirrored in read regs
    reg_wr(0, 12, 8'h5A); reg_rd(0, 12); chk("R7 B baud lo", rdata, 8'h5A);
    reg_wr(0, 13, 8'hA5); reg_rd(0, 13); chk("R2 B baud hi", rdata, 8'hA5);
    chk("R7 B cfg12", cfg_regs[12*8 +: 8], 8'h5A);
    // R3: pointer back at zero after write
    reg_wr(0, 6, 8'h33); ctl_rd(0); chk("R3 ptr cleared", rdata, 8'h44);
    chk("R3 reg6 stored", cfg_regs[6*8 +: 8], 8'h33);
    // R3: data accesses leave pointer alone
    ctl_wr(1, 8'h01); dat_wr(1, 8'h3C); ctl_rd(1); chk("R3 ptr kept", rdata, 8'h07);
    // R8: transmit strobe
    dat_wr(1, 8'hC3); chk("R8 tx A", tx_pulse, 2'b10); chk("R8 byte", tx_byte, 8'hC3);
    step(); chk("R8 tx one cycle", tx_pulse, 2'b00);
    // R1: channel B data write, then both strobes together
    dat_wr(0, 8'h12); chk("R1 tx B", tx_pulse, 2'b01);
    addr = ad(0, 1); wdata = 8'h77; wr_en = 1; rd_en = 1; step();
    chk("R1 write dropped", tx_pulse, 2'b00);
    // R9: receive path
    rx_load = 2'b10; rx_data = 16'h9900; step();
    chk("R9 refused disabled", rx_ready, 2'b00);
    reg_wr(1, 3, 8'h01); chk("R9 ready A", rx_ready, 2'b10);
    rx_load = 2'b10; rx_data = 16'h9900; step();
    chk("R9 busy", rx_ready, 2'b00);
    rx_load = 2'b10; rx_data = 16'h1100; step();
    ctl_rd(1); chk("R9 rxav set", rdata, 8'h45);
    dat_rd(1); chk("R9 first byte kept", rdata, 8'h99);
    chk("R9 ready again", rx_ready, 2'b10);
    // R10: rdata holds with no read
    step(); step(); chk("R10 hold", rdata, 8'h99);
    // R4: reset commands
    reg_wr(0, 5, 8'hFF); reg_wr(1, 5, 8'hEE);
    reg_wr(1, 9, 8'h40);
    chk("R4 B reset", cfg_regs[5*8 +: 8], 8'h00);
    chk("R4 A kept", cfg_regs[128 + 5*8 +: 8], 8'hEE);
    reg_wr(0, 9, 8'h00);
    chk("R4 noop A", cfg_regs[128 + 5*8 +: 8], 8'hEE);
    chk("R4 reg9 not stored", cfg_regs[9*8 +: 8], 8'hC0);
    reg_wr(0, 9, 8'h80);
    chk("R4 A reset", cfg_regs[128 + 5*8 +: 8], 8'h00);
    // R6: parked status value
    chan_off = 1; reg_wr(0, 9, 8'h80); chan_off = 0;
    ctl_rd(1); chk("R6 A parked", rdata, 8'h7C);
    ctl_rd(0); chk("R6 B unchanged", rdata, 8'h44);
    reg_wr(1, 9, 8'hC0); ctl_rd(1); chk("R4 both reset", rdata, 8'h44);
    // randomized traffic against the reference model
    for (int i = 0; i < 6000; i++) begin
      int k;
      k = $urandom_range(0, 99);
      addr = AW'($urandom);
      wdata = 8'($urandom);
      if (wdata[7:6] != 0 && $urandom_range(0, 3) != 0) wdata[7:6] = 0;
      wr_en = (k < 45);
      rd_en = (k >= 35 && k < 70);
      rx_load = 2'($urandom);
      rx_data = 16'($urandom);
      if ($urandom_range(0, 199) == 0) chan_off = ~chan_off;
      rst_n = ($urandom_range(0, 499) != 0);
      step();
      rst_n = 1;
    end
    done = 1;
    summary();
    $finish;
  end

endmodule